// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a general-purpose parallel port of `WIDTH` bits (1 to 32) on a small word-addressed slave bus. Four registers sit behind the bus. The output latch drives the port pins. The direction register sets which pins the block drives. The interrupt mask selects which captured edges may interrupt. The edge-capture register records input transitions. The bus interface has one write strobe and one read strobe, and read data returns one cycle after the read strobe.

The port kind is fixed at build time by `MODE`: input-only, output-only or bidirectional. A bidirectional port gives each pin its own driver enable, so an external pad can form the tristate buffer. Input pins pass through a two-stage synchroniser. Their transitions are compared against the previous synchronised sample. The edge kind is a build-time choice (`EDGE`: rising, falling or both), and software cannot change it. A matching transition sets its capture bit, and the bit holds until software clears it. The interrupt line is high while any capture bit is set and unmasked.

Top module: `parallel_io_port`

## Requirements
- R1: Registers sit at word offsets 0 (port data), 1 (direction), 2 (interrupt mask) and 3 (edge capture). A read strobe returns the register on `bus_rdata` with `bus_rvalid` high in the following cycle. Bits at and above `WIDTH` read as zero, and writes to those bits are ignored.
- R2: After reset, the direction, output latch, mask and capture registers are all zero. `irq` is low, and a bidirectional port drives no pin.
- R3: A write to offset 0 sets `pin_out` from the written low `WIDTH` bits, one cycle later, in bidirectional and output-only modes. In input-only mode `pin_out` stays zero.
- R4: A read of offset 0 returns the synchronised `pin_in` value, never the last written data. A pin change is visible to a read strobe issued three or more cycles later. An output-only port reads zero.
- R5: In bidirectional mode, `pin_oe` equals the direction register, and bit value 1 drives the pin. An output-only port holds `pin_oe` all ones and an input-only port all zeros. In both of those modes the direction register reads zero and ignores writes.
- R6: With rising-edge capture, only a 0-to-1 change of a synchronised input sets its capture bit.
- R7: With falling-edge capture, only a 1-to-0 change sets its capture bit.
- R8: With both-edge capture, either change sets its capture bit.
- R9: Writing a 1 to a capture bit clears it, and written 0 bits leave their bits unchanged. An edge arriving in the same cycle as its clear leaves the bit set. An output-only port never sets a capture bit.
- R10: `irq` is high exactly while some capture bit and its mask bit are both 1. It stays high until software clears those capture bits or masks them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word offset of the register accessed |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| pin_in | input | WIDTH | Port pin input values |
| pin_out | output | WIDTH | Values to drive on the port pins |
| pin_oe | output | WIDTH | Per-pin driver enable (1 drives) |
| irq | output | 1 | Interrupt request, level |

## Verification
A stale synchroniser or edge-history flop shows up within three cycles of a pin change. It appears as a wrong edge-capture readback, and as `irq` rising or failing to rise while the mask is set. A corrupted direction or output latch appears on `pin_oe` or `pin_out` in the cycle after the write that should have set it. A clear that wins over a coincident edge shows up in the very next capture read, because that bit reads zero instead of one. Four instances cover every port kind and edge kind. A fault tied to one mode therefore diverges only in that instance's readbacks.

// File: rtl/pario_pkg.sv
// Package: shared build-time choices and register offsets for the parallel port.
// Assumes the bus carries word offsets only; the offset order is decoded by pario_regs.
package pario_pkg;

    // Which pin directions a port instance supports.
    typedef enum logic [1:0] {
        PM_IN    = 2'd0,
        PM_OUT   = 2'd1,
        PM_BIDIR = 2'd2
    } port_mode_e;

    // Which input transitions are recorded in the capture register.
    typedef enum logic [1:0] {
        EK_RISE = 2'd0,
        EK_FALL = 2'd1,
        EK_ANY  = 2'd2
    } edge_kind_e;

    // Word offsets of the four registers.
    typedef enum logic [1:0] {
        RS_DATA = 2'd0,
        RS_DIR  = 2'd1,
        RS_MASK = 2'd2,
        RS_CAP  = 2'd3
    } reg_sel_e;

    localparam int BUS_W = 32;

endpackage

// File: rtl/pario_sync.sv
// Module: multi-stage synchroniser for asynchronous port inputs.
// Assumes each bit is sampled on its own; multi-bit coherence is not guaranteed.
module pario_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw pins through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pario_edge.sv
// Module: edge detector and sticky capture register.
// Assumes cur_in is already synchronous; the edge kind is fixed at build time.
// A clear from the bus loses to an edge in the same cycle.
module pario_edge
    import pario_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter edge_kind_e EDGE  = EK_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur_in,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] cap_bits
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] cap_q;

    // Remember the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_in;
    end

    // Pick the transition detector that matches the edge kind.
    generate
        case (EDGE)
            EK_RISE: begin : g_rise
                assign edge_hit = cur_in & ~prev_q;
            end
            EK_FALL: begin : g_fall
                assign edge_hit = ~cur_in & prev_q;
            end
            default: begin : g_any
                assign edge_hit = cur_in ^ prev_q;
            end
        endcase
    endgenerate

    // Clear the requested bits, then let new edges set bits again.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_bits) | edge_hit;
    end

    assign cap_bits = cap_q;

    // R9: every detected edge is present in the capture register one cycle later.
    a_r9_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((cap_q & $past(edge_hit)) == $past(edge_hit)));

    // R9: a capture bit only becomes set because an edge was seen.
    a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q & ~$past(cap_q) & ~$past(edge_hit)) == '0));

endmodule

// File: rtl/pario_regs.sv
// Module: register decode, output latch, direction, mask, read mux and interrupt.
// Assumes one bus access per cycle and WIDTH no larger than the bus width.
// Storage exists only for the features that the port mode provides.
module pario_regs
    import pario_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_mode_e MODE  = PM_BIDIR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr_en,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_rd_en,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             bus_rvalid,
    input  logic [WIDTH-1:0] in_sync,
    input  logic [WIDTH-1:0] cap_bits,
    output logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] out_bits,
    output logic [WIDTH-1:0] oe_bits,
    output logic             irq
);

    localparam bit HAS_OUT = (MODE != PM_IN);
    localparam bit HAS_IN  = (MODE != PM_OUT);
    localparam bit HAS_DIR = (MODE == PM_BIDIR);

    reg_sel_e         sel;
    logic             wr_data, wr_dir, wr_mask, wr_cap;
    logic [WIDTH-1:0] wr_bits;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] dir_view;
    logic [WIDTH-1:0] data_view;
    logic [WIDTH-1:0] rd_sel;
    logic [BUS_W-1:0] rd_word;
    logic [BUS_W-1:0] rdata_q;
    logic             rvalid_q;

    // Decode the offset into one write enable per register.
    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        wr_bits = bus_wdata[WIDTH-1:0];
        wr_data = bus_wr_en && (sel == RS_DATA);
        wr_dir  = bus_wr_en && (sel == RS_DIR);
        wr_mask = bus_wr_en && (sel == RS_MASK);
        wr_cap  = bus_wr_en && (sel == RS_CAP);
    end

    // Output latch only where the port can drive pins.
    generate
        if (HAS_OUT) begin : g_out
            logic [WIDTH-1:0] out_q;

            // Capture written data for the pin drivers.
            always_ff @(posedge clk) begin
                if (!rst_n)       out_q <= '0;
                else if (wr_data) out_q <= wr_bits;
            end

            assign out_bits = out_q;

            // R3: the pins show the written value one cycle after the write.
            a_r3_out_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
                wr_data |=> (out_bits == $past(wr_bits)));
        end else begin : g_no_out
            assign out_bits = '0;
        end
    endgenerate

    // Direction storage only for bidirectional ports; fixed enables otherwise.
    generate
        if (HAS_DIR) begin : g_dir
            logic [WIDTH-1:0] dir_q;

            // Hold the per-pin driver enables written by software.
            always_ff @(posedge clk) begin
                if (!rst_n)      dir_q <= '0;
                else if (wr_dir) dir_q <= wr_bits;
            end

            assign dir_view = dir_q;
            assign oe_bits  = dir_q;

            // R5: the driver enables change only through a direction write.
            a_r5_oe_from_dir: assert property (@(posedge clk) disable iff (!rst_n)
                wr_dir |=> (oe_bits == $past(wr_bits)));
            a_r5_oe_stable: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_dir |=> $stable(oe_bits));
        end else begin : g_fixed_dir
            assign dir_view = '0;
            assign oe_bits  = HAS_OUT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
        end
    endgenerate

    // The data read path shows the pins, never the output latch.
    generate
        if (HAS_IN) begin : g_in_view
            assign data_view = in_sync;
        end else begin : g_no_in_view
            assign data_view = '0;
        end
    endgenerate

    // Keep the interrupt mask written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wr_bits;
    end

    // Bits written as 1 to the capture offset are cleared.
    assign clr_bits = wr_cap ? wr_bits : '0;

    // Select the addressed register and zero-extend it to the bus width.
    always_comb begin
        case (sel)
            RS_DATA: rd_sel = data_view;
            RS_DIR:  rd_sel = dir_view;
            RS_MASK: rd_sel = mask_q;
            default: rd_sel = cap_bits;
        endcase
        rd_word            = '0;
        rd_word[WIDTH-1:0] = rd_sel;
    end

    // Register read data and its valid flag one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd_en;
            if (bus_rd_en) rdata_q <= rd_word;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign irq        = |(cap_bits & mask_q);

    // R1: every read strobe is answered in the next cycle.
    a_r1_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |=> bus_rvalid);

    // R10: without a capture clear or mask write, an asserted interrupt persists.
    a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_cap && !wr_mask) |=> irq);

endmodule

// File: rtl/parallel_io_port.sv
// Module: top of the parallel I/O port.
// Joins the synchroniser, edge capture and register bank for the chosen mode.
// Assumes the tristate pad sits outside this block: pin_out and pin_oe feed it.
module parallel_io_port
    import pario_pkg::*;
#(
    parameter int         WIDTH = 8,
    parameter port_mode_e MODE  = PM_BIDIR,
    parameter edge_kind_e EDGE  = EK_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr_en,
    input  logic [31:0]      bus_wdata,
    input  logic             bus_rd_en,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             irq
);

    localparam bit HAS_IN = (MODE != PM_OUT);

    logic [WIDTH-1:0] in_sync;
    logic [WIDTH-1:0] cap_bits;
    logic [WIDTH-1:0] clr_bits;

    // Reject a width that the bus cannot carry.
    generate
        if (WIDTH < 1 || WIDTH > BUS_W) begin : g_bad_width
            $error("parallel_io_port: WIDTH must lie in 1..32");
        end
    endgenerate

    // Input-side logic exists only where the port has inputs.
    generate
        if (HAS_IN) begin : g_inputs
            pario_sync #(
                .WIDTH  (WIDTH),
                .STAGES (2)
            ) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (pin_in),
                .sync_out (in_sync)
            );

            pario_edge #(
                .WIDTH (WIDTH),
                .EDGE  (EDGE)
            ) u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .cur_in   (in_sync),
                .clr_bits (clr_bits),
                .cap_bits (cap_bits)
            );
        end else begin : g_no_inputs
            assign in_sync  = '0;
            assign cap_bits = '0;
        end
    endgenerate

    pario_regs #(
        .WIDTH (WIDTH),
        .MODE  (MODE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr_en  (bus_wr_en),
        .bus_wdata  (bus_wdata),
        .bus_rd_en  (bus_rd_en),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .in_sync    (in_sync),
        .cap_bits   (cap_bits),
        .clr_bits   (clr_bits),
        .out_bits   (pin_out),
        .oe_bits    (pin_oe),
        .irq        (irq)
    );

endmodule

// File: tb/parallel_io_port_test.sv
// Bench: four port instances on one shared bus and pin stimulus.
// A: bidirectional rising, B: input falling, C: output-only, D: bidirectional both.
// Reads push expected words into a queue; a monitor pops them on read-valid.
module parallel_io_port_test;
    import pario_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr_en = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd_en = 1'b0;
    logic [W-1:0] pin_in = '0;

    logic [3:0][31:0]  rdata;
    logic [3:0]        rvalid;
    logic [3:0][W-1:0] pout;
    logic [3:0][W-1:0] poe;
    logic [3:0]        irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        string       req;
        logic [31:0] e0, e1, e2, e3;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    parallel_io_port #(.WIDTH(W), .MODE(PM_BIDIR), .EDGE(EK_RISE)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(rdata[0]),
        .bus_rvalid(rvalid[0]), .pin_in(pin_in), .pin_out(pout[0]),
        .pin_oe(poe[0]), .irq(irq[0]));

    parallel_io_port #(.WIDTH(W), .MODE(PM_IN), .EDGE(EK_FALL)) uut_in_fall (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(rdata[1]),
        .bus_rvalid(rvalid[1]), .pin_in(pin_in), .pin_out(pout[1]),
        .pin_oe(poe[1]), .irq(irq[1]));

    parallel_io_port #(.WIDTH(W), .MODE(PM_OUT), .EDGE(EK_ANY)) uut_out (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(rdata[2]),
        .bus_rvalid(rvalid[2]), .pin_in(pin_in), .pin_out(pout[2]),
        .pin_oe(poe[2]), .irq(irq[2]));

    parallel_io_port #(.WIDTH(W), .MODE(PM_BIDIR), .EDGE(EK_ANY)) uut_bi_any (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(rdata[3]),
        .bus_rvalid(rvalid[3]), .pin_in(pin_in), .pin_out(pout[3]),
        .pin_oe(poe[3]), .irq(irq[3]));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    // Driver: issue a read and queue the expected word for each instance.
    task automatic bus_read(logic [1:0] a, string req,
                            logic [31:0] e0, logic [31:0] e1,
                            logic [31:0] e2, logic [31:0] e3);
        exp_t item;
        item.req = req; item.e0 = e0; item.e1 = e1; item.e2 = e2; item.e3 = e3;
        @(negedge clk);
        bus_addr  = a;
        bus_rd_en = 1'b1;
        exp_q.push_back(item);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic set_pins(logic [W-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(string req, logic [3:0] exp);
        chk(req, {28'd0, irq}, {28'd0, exp});
    endtask

    // Monitor: compare each returned word with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rvalid[0]) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected read data", 32'd1, 32'd0);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                chk({it.req, " inst A"}, rdata[0], it.e0);
                chk({it.req, " inst B"}, rdata[1], it.e1);
                chk({it.req, " inst C"}, rdata[2], it.e2);
                chk({it.req, " inst D"}, rdata[3], it.e3);
                chk({it.req, " rvalid agree"}, {28'd0, rvalid}, 32'hF);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : stimulus
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R2 reset state
        chk("R2 pin_oe A", {24'd0, poe[0]}, 32'h00);
        chk("R2 pin_oe D", {24'd0, poe[3]}, 32'h00);
        chk("R2 pin_out A", {24'd0, pout[0]}, 32'h00);
        chk_irq("R2 irq", 4'b0000);
        bus_read(2'd1, "R2 direction", 0, 0, 0, 0);
        bus_read(2'd2, "R2 mask", 0, 0, 0, 0);
        bus_read(2'd3, "R2 capture", 0, 0, 0, 0);
        bus_read(2'd0, "R2 data", 0, 0, 0, 0);

        // R5 fixed enables in single-direction modes
        chk("R5 input-only oe", {24'd0, poe[1]}, 32'h00);
        chk("R5 output-only oe", {24'd0, poe[2]}, 32'hFF);

        // R3 data write drives pins; R4 read shows pins, not the latch
        bus_write(2'd0, 32'hFFFF_FFA5);
        chk("R3 pin_out A", {24'd0, pout[0]}, 32'hA5);
        chk("R3 pin_out input-only", {24'd0, pout[1]}, 32'h00);
        chk("R3 pin_out C", {24'd0, pout[2]}, 32'hA5);
        chk("R3 pin_out D", {24'd0, pout[3]}, 32'hA5);
        chk("R5 oe unchanged by data write", {24'd0, poe[0]}, 32'h00);
        bus_read(2'd0, "R4 read ignores written data", 0, 0, 0, 0);

        // R5 direction write, R1 upper bits dropped
        bus_write(2'd1, 32'hFFFF_FF0F);
        chk("R5 pin_oe A", {24'd0, poe[0]}, 32'h0F);
        chk("R5 pin_oe D", {24'd0, poe[3]}, 32'h0F);
        chk("R5 output-only oe after dir write", {24'd0, poe[2]}, 32'hFF);
        bus_read(2'd1, "R1 R5 direction readback", 32'h0F, 0, 0, 32'h0F);

        // R4 R6 R8 rising pattern on bits 2..5
        set_pins(8'h3C);
        idle(4);
        bus_read(2'd0, "R4 pin readback", 32'h3C, 32'h3C, 0, 32'h3C);
        bus_read(2'd3, "R6 R7 R8 rise capture", 32'h3C, 0, 0, 32'h3C);
        chk_irq("R10 masked off", 4'b0000);

        // R7 falling pattern
        set_pins(8'h00);
        idle(4);
        bus_read(2'd3, "R6 R7 R8 fall capture", 32'h3C, 32'h3C, 0, 32'h3C);

        // R10 mask enables the interrupt
        bus_write(2'd2, 32'h0000_0004);
        chk_irq("R10 irq with mask", 4'b1011);
        bus_read(2'd2, "R1 mask readback", 4, 4, 4, 4);

        // R9 partial clear, R10 irq drops
        bus_write(2'd3, 32'h0000_0004);
        chk_irq("R10 irq after clear", 4'b0000);
        bus_read(2'd3, "R9 partial clear", 32'h38, 32'h38, 0, 32'h38);
        bus_write(2'd3, 32'hFFFF_FFFF);
        bus_read(2'd3, "R9 full clear", 0, 0, 0, 0);

        // R6 R7 R8 polarity on bit 0
        set_pins(8'h01);
        idle(4);
        bus_read(2'd3, "R6 R7 R8 bit0 rise", 1, 0, 0, 1);
        bus_write(2'd3, 32'hFF);
        set_pins(8'h00);
        idle(4);
        bus_read(2'd3, "R6 R7 R8 bit0 fall", 0, 1, 0, 1);
        bus_write(2'd3, 32'hFF);
        idle(2);

        // R9 edge wins over a clear in the same cycle
        set_pins(8'h01);
        @(negedge clk);
        bus_write(2'd3, 32'h0000_0001);
        bus_read(2'd3, "R9 coincident edge kept", 1, 0, 0, 1);
        chk_irq("R10 bit0 not masked", 4'b0000);

        // R10 mask change alone raises the line, clear drops it
        bus_write(2'd2, 32'h0000_0001);
        chk_irq("R10 irq bit0 masked in", 4'b1001);
        idle(3);
        chk_irq("R10 irq held", 4'b1001);
        bus_write(2'd3, 32'h0000_0001);
        chk_irq("R10 irq after clear", 4'b0000);

        idle(4);
        chk("R1 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule